// File: doc/BRIEF.md
# Half-Bridge Gate Interlock

This block is the digital control core for two independent half-bridge power stages. Each stage has a high-side and a low-side gate command. Every command arrives as a pair of wires, one true and one inverted, and a gate may only turn on when the pair agrees. The block combines these commands with three conditions: a global wake request, a supply-in-window flag and a charge-pump-ready flag. It also uses a per-channel over-temperature fault and measured gate-off feedback from each external FET. From these it produces four registered gate-on requests for the analog drivers.

Shoot-through protection has no fixed dead-time counter. When the interlock is active, a gate is qualified by the opposite FET's reported gate-off status. The interlock is controlled by an active-low pin: holding it low keeps the interlock active, and driving it high allows both gates of a channel to conduct together. Every asynchronous input passes through a two-flop synchronizer, and the outputs are registered.

Top module: `hb_gate_interlock`

## Requirements
- R1: A gate output can be 1 only while its true command input is 1 and its inverted command input is 0. The other three pair states, 00, 11 and true 0 with inverted 1, keep that gate off.
- R2: The bridge is enabled only when `wake_i`, `supply_ok_i` and `cp_ready_i` are all 1. If any one of them is 0, all four gate outputs are 0.
- R3: While `overlap_ok_i` is 0, a high-side gate turns on only while that channel's `lo_off_fb_i` bit is 1 (1 = FET off). A low-side gate turns on only while that channel's `hi_off_fb_i` bit is 1. No cycle shows a gate on while the opposite FET's feedback reports it on.
- R4: While `overlap_ok_i` is 1, the off-feedback inputs have no effect, and both gates of one channel may be on together.
- R5: A 1 on `therm_fault_i[c]` forces both gate outputs of channel c to 0.
- R6: The channels are independent. A fault, feedback change or command change on one channel leaves the other channel's outputs unchanged.
- R7: An input change that is present at rising edge k appears at the outputs just after rising edge k+2. The path is two synchronizer stages and one output register.
- R8: While `rst_n` is 0 and after it is released, all gate outputs are 0 until enabling inputs have propagated. The off-feedback synchronizers reset to the "FET off" value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wake_i | input | 1 | Global wake request |
| supply_ok_i | input | 1 | Supply voltage inside its window |
| cp_ready_i | input | 1 | Charge pump ready |
| overlap_ok_i | input | 1 | 0 = shoot-through interlock active, 1 = overlap allowed |
| hi_cmd_i | input | NUM_CH | High-side command, true polarity, one bit per channel |
| hi_cmd_n_i | input | NUM_CH | High-side command, inverted polarity |
| lo_cmd_i | input | NUM_CH | Low-side command, true polarity |
| lo_cmd_n_i | input | NUM_CH | Low-side command, inverted polarity |
| hi_off_fb_i | input | NUM_CH | High-side FET gate-off status (1 = off) |
| lo_off_fb_i | input | NUM_CH | Low-side FET gate-off status (1 = off) |
| therm_fault_i | input | NUM_CH | Per-channel over-temperature fault |
| hi_gate_o | output | NUM_CH | High-side gate-on request |
| lo_gate_o | output | NUM_CH | Low-side gate-on request |

## Verification
The embedded assertions check the following rules on every cycle, each against the synchronized values one register earlier: an invalid command pair keeps a gate off, a dropped bridge enable clears all outputs, a thermal fault clears its channel, and an active interlock with the opposite FET on blocks a gate. They also check that, with overlap allowed, a fully qualified command does turn the gate on. The bench scenarios cover what depends on the ports and on time. These are the three-edge latency, the reset behaviour, the release of each enable term, and the independence of the two channels under a fault or feedback change on the neighbour. A bench monitor also checks at every cycle that no gate is asserted while the delayed feedback at the ports shows the opposite FET on under an active interlock.

// File: rtl/hb_interlock_pkg.sv
// Package: shared types and helpers for the half-bridge gate interlock.
// Assumes: command pairs are a true wire and an inverted wire.
package hb_interlock_pkg;

    // Per-channel synchronized input bundle.
    typedef struct packed {
        logic hi_t;
        logic hi_n;
        logic lo_t;
        logic lo_n;
        logic hi_off;
        logic lo_off;
        logic fault;
    } chan_in_t;

    // A command pair asks for "on" only when true=1 and inverted=0.
    function automatic logic pair_on(input logic t, input logic n);
        return t & ~n;
    endfunction

endpackage

// File: rtl/hb_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes: STAGES >= 2; each bit is an independent level signal.
module hb_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    // Shift the input through the flop chain; reset loads the safe value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hb_bridge_enable.sv
// Module: forms the bridge enable from the synchronized wake,
// supply-window and charge-pump-ready flags.
// Assumes: all three inputs are already synchronized.
module hb_bridge_enable (
    input  logic wake_s,
    input  logic supply_ok_s,
    input  logic cp_ready_s,
    output logic bridge_en
);
    // All three conditions must hold for the bridge to run.
    always_comb begin
        bridge_en = wake_s & supply_ok_s & cp_ready_s;
    end
endmodule

// File: rtl/hb_channel.sv
// Module: one half-bridge channel. It qualifies the high and low gate
// commands with the bridge enable, thermal fault and shoot-through
// interlock, then registers the gate requests.
// Assumes: inputs are synchronized; off feedback 1 means FET is off.
module hb_channel
    import hb_interlock_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  chan_in_t in_s,
    input  logic     bridge_en,
    input  logic     overlap_ok_s,
    output logic     hi_gate_o,
    output logic     lo_gate_o
);
    logic hi_req, lo_req;
    logic hi_xc_en, lo_xc_en;
    logic hi_nxt, lo_nxt;

    // Decode the command pairs and the cross-conduction terms.
    always_comb begin
        hi_req   = pair_on(in_s.hi_t, in_s.hi_n);
        lo_req   = pair_on(in_s.lo_t, in_s.lo_n);
        hi_xc_en = overlap_ok_s | in_s.lo_off;
        lo_xc_en = overlap_ok_s | in_s.hi_off;
        hi_nxt   = hi_req & bridge_en & hi_xc_en & ~in_s.fault;
        lo_nxt   = lo_req & bridge_en & lo_xc_en & ~in_s.fault;
    end

    // Register the gate requests; reset holds both gates off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_gate_o <= 1'b0;
            lo_gate_o <= 1'b0;
        end else begin
            hi_gate_o <= hi_nxt;
            lo_gate_o <= lo_nxt;
        end
    end

    assert_hi_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_s.hi_t && !in_s.hi_n) |=> !hi_gate_o);
    assert_lo_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_s.lo_t && !in_s.lo_n) |=> !lo_gate_o);
    assert_hi_wait_lo_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!overlap_ok_s && !in_s.lo_off) |=> !hi_gate_o);
    assert_lo_wait_hi_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!overlap_ok_s && !in_s.hi_off) |=> !lo_gate_o);
    assert_overlap_both_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (overlap_ok_s && bridge_en && !in_s.fault && in_s.hi_t && !in_s.hi_n
         && in_s.lo_t && !in_s.lo_n) |=> (hi_gate_o && lo_gate_o));
    assert_fault_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_s.fault |=> (!hi_gate_o && !lo_gate_o));
endmodule

// File: rtl/hb_gate_interlock.sv
// Module: top of the two-channel half-bridge gate interlock.
// It synchronizes all asynchronous inputs, builds the bridge enable,
// and runs one qualification channel per half-bridge.
// Assumes: all inputs are asynchronous levels; outputs feed gate drivers.
module hb_gate_interlock
    import hb_interlock_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wake_i,
    input  logic              supply_ok_i,
    input  logic              cp_ready_i,
    input  logic              overlap_ok_i,
    input  logic [NUM_CH-1:0] hi_cmd_i,
    input  logic [NUM_CH-1:0] hi_cmd_n_i,
    input  logic [NUM_CH-1:0] lo_cmd_i,
    input  logic [NUM_CH-1:0] lo_cmd_n_i,
    input  logic [NUM_CH-1:0] hi_off_fb_i,
    input  logic [NUM_CH-1:0] lo_off_fb_i,
    input  logic [NUM_CH-1:0] therm_fault_i,
    output logic [NUM_CH-1:0] hi_gate_o,
    output logic [NUM_CH-1:0] lo_gate_o
);
    localparam int CMD_W  = 2 * NUM_CH;
    localparam int CTRL_W = 4;

    logic [CMD_W-1:0]  cmd_t_s, cmd_n_s, off_fb_s;
    logic [NUM_CH-1:0] fault_s;
    logic [CTRL_W-1:0] ctrl_s;
    logic              bridge_en;

    // True commands reset to "not requested".
    hb_sync #(.W(CMD_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_cmd_t (
        .clk(clk), .rst_n(rst_n), .d({lo_cmd_i, hi_cmd_i}), .q(cmd_t_s));

    // Inverted commands reset to their inactive (high) level.
    hb_sync #(.W(CMD_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync_cmd_n (
        .clk(clk), .rst_n(rst_n), .d({lo_cmd_n_i, hi_cmd_n_i}), .q(cmd_n_s));

    // Off feedback resets to "FET is off".
    hb_sync #(.W(CMD_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync_fb (
        .clk(clk), .rst_n(rst_n), .d({lo_off_fb_i, hi_off_fb_i}), .q(off_fb_s));

    hb_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_fault (
        .clk(clk), .rst_n(rst_n), .d(therm_fault_i), .q(fault_s));

    // Control flags reset low: bridge disabled, interlock active.
    hb_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_ctrl (
        .clk(clk), .rst_n(rst_n),
        .d({overlap_ok_i, cp_ready_i, supply_ok_i, wake_i}), .q(ctrl_s));

    hb_bridge_enable u_bridge_en (
        .wake_s     (ctrl_s[0]),
        .supply_ok_s(ctrl_s[1]),
        .cp_ready_s (ctrl_s[2]),
        .bridge_en  (bridge_en)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        chan_in_t ch_in;

        // Gather this channel's synchronized signals into one bundle.
        always_comb begin
            ch_in.hi_t   = cmd_t_s[c];
            ch_in.lo_t   = cmd_t_s[NUM_CH + c];
            ch_in.hi_n   = cmd_n_s[c];
            ch_in.lo_n   = cmd_n_s[NUM_CH + c];
            ch_in.hi_off = off_fb_s[c];
            ch_in.lo_off = off_fb_s[NUM_CH + c];
            ch_in.fault  = fault_s[c];
        end

        hb_channel u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .in_s        (ch_in),
            .bridge_en   (bridge_en),
            .overlap_ok_s(ctrl_s[3]),
            .hi_gate_o   (hi_gate_o[c]),
            .lo_gate_o   (lo_gate_o[c])
        );
    end

    assert_bridge_off_all_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bridge_en |=> (hi_gate_o == '0 && lo_gate_o == '0));
    assert_reset_outputs_low_R8: assert property (@(posedge clk)
        !rst_n |=> (hi_gate_o == '0 && lo_gate_o == '0));
endmodule

// File: tb/hb_gate_interlock_bench.sv
// Bench: directed scenarios for the two-channel gate interlock.
module hb_gate_interlock_bench;
    localparam int N = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wake_i = 1'b0, supply_ok_i = 1'b0, cp_ready_i = 1'b0, overlap_ok_i = 1'b0;
    logic [N-1:0] hi_cmd_i = '0, hi_cmd_n_i = '1, lo_cmd_i = '0, lo_cmd_n_i = '1;
    logic [N-1:0] hi_off_fb_i = '1, lo_off_fb_i = '1, therm_fault_i = '0;
    logic [N-1:0] hi_gate_o, lo_gate_o;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hb_gate_interlock #(.NUM_CH(N), .SYNC_STAGES(2)) u_hb_gate_interlock (
        .clk(clk), .rst_n(rst_n), .wake_i(wake_i), .supply_ok_i(supply_ok_i),
        .cp_ready_i(cp_ready_i), .overlap_ok_i(overlap_ok_i),
        .hi_cmd_i(hi_cmd_i), .hi_cmd_n_i(hi_cmd_n_i),
        .lo_cmd_i(lo_cmd_i), .lo_cmd_n_i(lo_cmd_n_i),
        .hi_off_fb_i(hi_off_fb_i), .lo_off_fb_i(lo_off_fb_i),
        .therm_fault_i(therm_fault_i),
        .hi_gate_o(hi_gate_o), .lo_gate_o(lo_gate_o));

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Wait until an input change has crossed both sync stages and the output flop.
    task automatic settle();
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic drive_idle();
        @(negedge clk);
        wake_i = 1; supply_ok_i = 1; cp_ready_i = 1; overlap_ok_i = 0;
        hi_cmd_i = '0; hi_cmd_n_i = '1; lo_cmd_i = '0; lo_cmd_n_i = '1;
        hi_off_fb_i = '1; lo_off_fb_i = '1; therm_fault_i = '0;
    endtask

    task automatic all_cmds_on();
        @(negedge clk);
        hi_cmd_i = '1; hi_cmd_n_i = '0; lo_cmd_i = '1; lo_cmd_n_i = '0;
    endtask

    // R3 monitor: port history, three deep, to match the output latency.
    logic [N-1:0] hfb_d0 = '1, hfb_d1 = '1, hfb_d2 = '1;
    logic [N-1:0] lfb_d0 = '1, lfb_d1 = '1, lfb_d2 = '1;
    logic ovl_d0 = 1'b1, ovl_d1 = 1'b1, ovl_d2 = 1'b1;
    always @(posedge clk) begin
        hfb_d2 <= hfb_d1; hfb_d1 <= hfb_d0; hfb_d0 <= hi_off_fb_i;
        lfb_d2 <= lfb_d1; lfb_d1 <= lfb_d0; lfb_d0 <= lo_off_fb_i;
        ovl_d2 <= ovl_d1; ovl_d1 <= ovl_d0; ovl_d0 <= overlap_ok_i;
    end
    always @(negedge clk) begin
        if (rst_n && !done && !ovl_d2) begin
            chk("R3 monitor hi on vs low fb on", hi_gate_o & ~lfb_d2, '0);
            chk("R3 monitor lo on vs high fb on", lo_gate_o & ~hfb_d2, '0);
        end
    end

    task automatic t_reset();
        rst_n = 0;
        @(negedge clk);
        wake_i = 1; supply_ok_i = 1; cp_ready_i = 1;
        hi_cmd_i = '1; hi_cmd_n_i = '0;
        repeat (4) @(posedge clk);
        #1;
        chk("R8 hi during reset", hi_gate_o, '0);
        chk("R8 lo during reset", lo_gate_o, '0);
        @(negedge clk);
        rst_n = 1;
        @(posedge clk); #1;
        chk("R8 hi first cycle after reset", hi_gate_o, '0);
        drive_idle();
        settle();
        chk("R8 idle hi", hi_gate_o, '0);
        chk("R8 idle lo", lo_gate_o, '0);
    endtask

    task automatic t_pairs();
        drive_idle();
        for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            hi_cmd_i[0] = p[1]; hi_cmd_n_i[0] = p[0];
            settle();
            chk($sformatf("R1 high pair t=%0d n=%0d", p[1], p[0]),
                hi_gate_o, {1'b0, (p == 2) ? 1'b1 : 1'b0});
        end
        for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            lo_cmd_i[1] = p[1]; lo_cmd_n_i[1] = p[0];
            settle();
            chk($sformatf("R1 low pair t=%0d n=%0d", p[1], p[0]),
                lo_gate_o, {(p == 2) ? 1'b1 : 1'b0, 1'b0});
        end
    endtask

    task automatic t_latency();
        drive_idle();
        settle();
        @(negedge clk);
        lo_cmd_i[0] = 1; lo_cmd_n_i[0] = 0;
        repeat (2) @(posedge clk); #1;
        chk("R7 not yet after two edges", lo_gate_o, 2'b00);
        @(posedge clk); #1;
        chk("R7 visible after third edge", lo_gate_o, 2'b01);
    endtask

    task automatic t_bridge();
        drive_idle();
        @(negedge clk); overlap_ok_i = 1;
        all_cmds_on();
        settle();
        chk("R2 all on hi", hi_gate_o, '1);
        chk("R2 all on lo", lo_gate_o, '1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            wake_i = (k != 0); supply_ok_i = (k != 1); cp_ready_i = (k != 2);
            settle();
            chk($sformatf("R2 term %0d low hi", k), hi_gate_o, '0);
            chk($sformatf("R2 term %0d low lo", k), lo_gate_o, '0);
        end
        @(negedge clk); wake_i = 1; supply_ok_i = 1; cp_ready_i = 1;
        settle();
        chk("R2 restored hi", hi_gate_o, '1);
        chk("R2 restored lo", lo_gate_o, '1);
    endtask

    task automatic t_interlock();
        drive_idle();
        all_cmds_on();
        @(negedge clk); lo_off_fb_i[0] = 0;
        settle();
        chk("R3 hi blocked by low fb on", hi_gate_o, 2'b10);
        chk("R3 lo allowed when high fb off", lo_gate_o, 2'b11);
        @(negedge clk); lo_off_fb_i[0] = 1; hi_off_fb_i[1] = 0;
        settle();
        chk("R3 lo blocked by high fb on", lo_gate_o, 2'b01);
        chk("R3 hi released", hi_gate_o, 2'b11);
    endtask

    task automatic t_overlap();
        drive_idle();
        all_cmds_on();
        @(negedge clk); overlap_ok_i = 1; hi_off_fb_i = '0; lo_off_fb_i = '0;
        settle();
        chk("R4 overlap hi ignores fb", hi_gate_o, '1);
        chk("R4 overlap lo ignores fb", lo_gate_o, '1);
        @(negedge clk); overlap_ok_i = 0;
        settle();
        chk("R3 interlock back on hi", hi_gate_o, '0);
        chk("R3 interlock back on lo", lo_gate_o, '0);
    endtask

    task automatic t_thermal();
        drive_idle();
        @(negedge clk); overlap_ok_i = 1;
        all_cmds_on();
        for (int c = 0; c < N; c++) begin
            @(negedge clk); therm_fault_i = '0; therm_fault_i[c] = 1;
            settle();
            chk($sformatf("R5 fault ch%0d hi", c), hi_gate_o, ~(2'b01 << c));
            chk($sformatf("R5 R6 fault ch%0d lo", c), lo_gate_o, ~(2'b01 << c));
        end
    endtask

    task automatic t_indep();
        drive_idle();
        all_cmds_on();
        settle();
        chk("R6 baseline hi", hi_gate_o, '1);
        @(negedge clk); hi_cmd_n_i[0] = 1; lo_off_fb_i[0] = 0;
        settle();
        chk("R6 ch1 hi unchanged", hi_gate_o[1], 1'b1);
        chk("R6 ch1 lo unchanged", lo_gate_o[1], 1'b1);
        chk("R6 ch0 hi off", hi_gate_o[0], 1'b0);
        @(negedge clk); therm_fault_i[1] = 1;
        settle();
        chk("R6 ch0 lo unaffected by ch1 fault", lo_gate_o, 2'b01);
    endtask

    initial begin
        t_reset();
        t_pairs();
        t_latency();
        t_bridge();
        t_interlock();
        t_overlap();
        t_thermal();
        t_indep();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog R1-path run actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule